// File: doc/BRIEF.md
# Load-Store Address Alignment Unit

This block sits between an integer execution stage and a 32-bit big-endian data memory. For each memory request it adds operand A to either operand B or a sign-extended 16-bit immediate. It then forces the sum onto the natural boundary of the access size. For stores it produces per-lane write enables and write data copied across the lanes. For loads it picks the addressed byte or halfword out of the returned word and zero-extends it to 32 bits.

The 6-bit opcode selects the access. The two upper bits must be `11`. Bit 3 picks the immediate instead of operand B. Bit 2 marks a store. Bits 1:0 give the size: `00` byte, `01` halfword, `10` word. A size code of `11`, or any opcode outside the `11xxxx` group, makes no access. Misaligned addresses never trap: the low address bits are cleared. Every load is unsigned.

The address phase is registered: memory outputs appear one clock after the request. A synchronous memory returns read data one clock after that. The formatted load result is available in that same cycle.

Top module: `lsu_align_unit`

## Requirements
- R1: After reset, and until the first accepted request, memValid, memWrite, loadValid and byteEn are all zero.
- R2: The effective address is opA + opB for opcodes 0x30 to 0x36, and opA + the sign-extended 16-bit immVal for opcodes 0x38 to 0x3E; a byte access presents it unmodified on memAddr.
- R3: A halfword access (size code 01) clears address bit 0, and a word access (size code 10) clears address bits 1:0, before memAddr is driven.
- R4: byteEn bit 3 covers data bits 31:24 and bit 0 covers bits 7:0; a byte store at offset k raises only bit 3-k, a halfword store at offset 0 raises 4'b1100 and at offset 2 raises 4'b0011, a word store raises 4'b1111, and a load raises no enable.
- R5: Store write data is the low byte copied into all four lanes for a byte store, the low halfword copied into both halves for a halfword store, and storeData unchanged for a word store.
- R6: A byte load at offset k returns readData bits (31-8k) down to (24-8k), a halfword load at offset 0 returns bits 31:16 and at offset 2 returns bits 15:0, and a word load returns readData; byte and halfword results are zero-extended to 32 bits.
- R7: memValid and the address outputs appear in the cycle after reqValid is sampled; loadValid and loadResult appear one cycle after memValid for a load, and loadResult is zero when loadValid is low.
- R8: A request with reqValid low, an opcode outside 0x30 to 0x3F, or a size code of 11 (for example 0x33 or 0x3F) makes no access: memValid, memWrite and byteEn stay zero, and no loadValid follows.
- R9: memWrite is high exactly for accepted store opcodes (bit 2 set) and never produces a following loadValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| opcode | input | 6 | Access opcode |
| opA | input | 32 | Base operand |
| opB | input | 32 | Register offset operand |
| immVal | input | 16 | Immediate offset, sign-extended |
| storeData | input | 32 | Data to store, right-justified |
| readData | input | 32 | Word returned by memory one cycle after a load address |
| memValid | output | 1 | Memory access this cycle |
| memWrite | output | 1 | Access is a store |
| memAddr | output | 32 | Aligned byte address |
| byteEn | output | 4 | Per-lane write enables, bit 3 = bits 31:24 |
| writeData | output | 32 | Lane-positioned store data |
| loadValid | output | 1 | Load result valid |
| loadResult | output | 32 | Zero-extended load data |

## Verification
On every cycle the assertions check several relations. Word and halfword addresses must be aligned. A load must carry no enables and a store must carry one, two or four according to its size. An idle cycle must show no enables. A load must be followed by loadValid and a store must not. A byte load result must have zero upper bits. Only the bench's scenarios can show the rest: that the sum used the right operand, that the single active lane matches the offset, that store data was copied into the right lanes, and that the right byte or halfword was picked from memory. Those scenarios use directed offsets, invalid opcodes and a store followed at once by a load of the same word.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } accSize_e;

  // strobes decoded from the opcode in the request cycle
  typedef struct packed {
    logic     access;
    logic     store;
    logic     useImm;
    accSize_e size;
  } lsuStrobe_t;

  // state carried by one pipeline stage
  typedef struct packed {
    logic     valid;
    logic     write;
    accSize_e size;
  } lsuStage_t;

endpackage

// File: rtl/lsu_align_ctrl.sv
module lsu_align_ctrl
  import lsu_align_pkg::*;
#(
  parameter int OPC_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [OPC_W-1:0] opcode,
  output lsuStrobe_t       reqStb,
  output lsuStage_t        memStg,
  output lsuStage_t        ldStg
);

  logic groupHit;
  logic sizeOk;

  always_comb begin
    groupHit      = (opcode[OPC_W-1 -: 2] == 2'b11);
    sizeOk        = (opcode[1:0] != 2'b11);
    reqStb.access = reqValid && groupHit && sizeOk;
    reqStb.store  = opcode[2];
    reqStb.useImm = opcode[3];
    reqStb.size   = sizeOk ? accSize_e'(opcode[1:0]) : SZ_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memStg <= '{valid: 1'b0, write: 1'b0, size: SZ_NONE};
      ldStg  <= '{valid: 1'b0, write: 1'b0, size: SZ_NONE};
    end else begin
      memStg.valid <= reqStb.access;
      memStg.write <= reqStb.access && reqStb.store;
      memStg.size  <= reqStb.access ? reqStb.size : SZ_NONE;
      ldStg.valid  <= memStg.valid && !memStg.write;
      ldStg.write  <= 1'b0;
      ldStg.size   <= memStg.size;
    end
  end

  // R7: an address phase of a load is followed by a load result
  a_r7_load_follows: assert property (@(posedge clk) disable iff (!rstN)
    (memStg.valid && !memStg.write) |=> ldStg.valid);

  // R9: a store never yields a load result
  a_r9_store_no_load: assert property (@(posedge clk) disable iff (!rstN)
    (memStg.valid && memStg.write) |=> !ldStg.valid);

  // R8: no write strobe without an access
  a_r8_write_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    !memStg.valid |-> !memStg.write);

endmodule

// File: rtl/lsu_align_dp.sv
module lsu_align_dp
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  lsuStrobe_t             reqStb,
  input  lsuStage_t              memStg,
  input  lsuStage_t              ldStg,
  input  logic [ADDR_W-1:0]      opA,
  input  logic [ADDR_W-1:0]      opB,
  input  logic [IMM_W-1:0]       immVal,
  input  logic [DATA_W-1:0]      storeData,
  input  logic [DATA_W-1:0]      readData,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [DATA_W/8-1:0]    byteEn,
  output logic [DATA_W-1:0]      writeData,
  output logic [DATA_W-1:0]      loadResult
);

  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);

  function automatic int unsigned sizeBytes(accSize_e s);
    case (s)
      SZ_BYTE: sizeBytes = 1;
      SZ_HALF: sizeBytes = 2;
      default: sizeBytes = LANES;
    endcase
  endfunction

  logic [ADDR_W-1:0] immExt;
  logic [ADDR_W-1:0] rawAddr;
  logic [ADDR_W-1:0] alignedAddr;
  logic [OFS_W-1:0]  lowMask;
  logic [OFS_W-1:0]  laneOfs;
  int unsigned       accBytes;
  logic [LANES-1:0]  byteEnNext;
  logic [DATA_W-1:0] wdNext;
  logic [OFS_W-1:0]  ldOfs;

  // effective address and alignment
  always_comb begin
    immExt      = {{(ADDR_W-IMM_W){immVal[IMM_W-1]}}, immVal};
    rawAddr     = opA + (reqStb.useImm ? immExt : opB);
    accBytes    = sizeBytes(reqStb.size);
    lowMask     = OFS_W'(accBytes - 1);
    alignedAddr = {rawAddr[ADDR_W-1:OFS_W], rawAddr[OFS_W-1:0] & ~lowMask};
    laneOfs     = alignedAddr[OFS_W-1:0];
  end

  // lane l counts from the most significant byte (big-endian)
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    int unsigned srcIdx;
    logic        inRange;
    always_comb begin
      inRange = (l >= int'(laneOfs)) && (l < int'(laneOfs) + int'(accBytes));
      byteEnNext[LANES-1-l] = reqStb.store && inRange;
      srcIdx = (LANES - 1 - l) & (accBytes - 1);
      wdNext[DATA_W-1-8*l -: 8] = storeData[8*srcIdx +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr   <= '0;
      byteEn    <= '0;
      writeData <= '0;
      ldOfs     <= '0;
    end else begin
      memAddr   <= reqStb.access ? alignedAddr : '0;
      byteEn    <= reqStb.access ? byteEnNext : '0;
      writeData <= (reqStb.access && reqStb.store) ? wdNext : '0;
      ldOfs     <= memAddr[OFS_W-1:0];
    end
  end

  // load lane selection and zero extension
  always_comb begin
    int unsigned shiftBits;
    loadResult = '0;
    shiftBits  = 0;
    if (ldStg.valid) begin
      case (ldStg.size)
        SZ_BYTE: begin
          shiftBits  = 8 * (LANES - 1 - int'(ldOfs));
          loadResult = DATA_W'(readData[shiftBits +: 8]);
        end
        SZ_HALF: begin
          shiftBits  = 8 * (LANES - 2 - int'(ldOfs));
          loadResult = DATA_W'(readData[shiftBits +: 16]);
        end
        default: loadResult = readData;
      endcase
    end
  end

  // R3: word addresses aligned to the bus width
  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (memStg.valid && memStg.size == SZ_WORD) |-> memAddr[OFS_W-1:0] == '0);

  // R3: halfword addresses even
  a_r3_half_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (memStg.valid && memStg.size == SZ_HALF) |-> !memAddr[0]);

  // R4: loads drive no enables
  a_r4_load_no_enables: assert property (@(posedge clk) disable iff (!rstN)
    (memStg.valid && !memStg.write) |-> byteEn == '0);

  // R4: a store enables as many lanes as its size
  a_r4_store_lane_count: assert property (@(posedge clk) disable iff (!rstN)
    (memStg.valid && memStg.write) |->
      $countones(byteEn) == ((memStg.size == SZ_BYTE) ? 1 :
                             (memStg.size == SZ_HALF) ? 2 : LANES));

  // R8: idle cycles drive no enables
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !memStg.valid |-> byteEn == '0);

  // R6: byte loads are zero-extended
  a_r6_byte_zero_ext: assert property (@(posedge clk) disable iff (!rstN)
    (ldStg.valid && ldStg.size == SZ_BYTE) |-> loadResult[DATA_W-1:8] == '0);

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int OPC_W  = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [OPC_W-1:0]    opcode,
  input  logic [ADDR_W-1:0]   opA,
  input  logic [ADDR_W-1:0]   opB,
  input  logic [IMM_W-1:0]    immVal,
  input  logic [DATA_W-1:0]   storeData,
  input  logic [DATA_W-1:0]   readData,
  output logic                memValid,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] byteEn,
  output logic [DATA_W-1:0]   writeData,
  output logic                loadValid,
  output logic [DATA_W-1:0]   loadResult
);

  lsuStrobe_t reqStb;
  lsuStage_t  memStg;
  lsuStage_t  ldStg;

  lsu_align_ctrl #(.OPC_W(OPC_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .opcode   (opcode),
    .reqStb   (reqStb),
    .memStg   (memStg),
    .ldStg    (ldStg)
  );

  lsu_align_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_W(IMM_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqStb     (reqStb),
    .memStg     (memStg),
    .ldStg      (ldStg),
    .opA        (opA),
    .opB        (opB),
    .immVal     (immVal),
    .storeData  (storeData),
    .readData   (readData),
    .memAddr    (memAddr),
    .byteEn     (byteEn),
    .writeData  (writeData),
    .loadResult (loadResult)
  );

  assign memValid  = memStg.valid;
  assign memWrite  = memStg.write;
  assign loadValid = ldStg.valid;

endmodule

// File: tb/test_lsu_align_unit.sv
`timescale 1ns/1ps
module test_lsu_align_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [5:0]  opcode = '0;
  logic [31:0] opA = '0, opB = '0, storeData = '0;
  logic [15:0] immVal = '0;
  logic [31:0] readData = '0;
  logic        memValid, memWrite, loadValid;
  logic [31:0] memAddr, writeData, loadResult;
  logic [3:0]  byteEn;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lsu_align_unit i_lsu_align_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opcode(opcode),
    .opA(opA), .opB(opB), .immVal(immVal), .storeData(storeData),
    .readData(readData), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .byteEn(byteEn), .writeData(writeData),
    .loadValid(loadValid), .loadResult(loadResult)
  );

  // simple synchronous memory model, 64 words
  logic [31:0] mem [64];
  initial begin
    for (int i = 0; i < 64; i++)
      mem[i] = {8'(i), 8'(i + 8'h40), 8'(i + 8'h80), 8'(i + 8'hC0)};
  end
  always @(posedge clk) begin
    if (memValid && !memWrite) readData <= mem[memAddr[7:2]];
    if (memValid && memWrite)
      for (int l = 0; l < 4; l++)
        if (byteEn[l]) mem[memAddr[7:2]][8*l +: 8] <= writeData[8*l +: 8];
  end

  // expected state of each stage
  bit          eMemValid = 0, eMemWrite = 0, eLdValid = 0;
  logic [31:0] eAddr = 0, eWdata = 0, eLoad = 0;
  logic [3:0]  eEn = 0;
  int          eSize = 0;
  bit          nMemValid, nMemWrite;
  logic [31:0] nAddr, nWdata;
  logic [3:0]  nEn;
  int          nSize;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model of one request
  task automatic model(bit v, logic [5:0] opc, logic [31:0] a, logic [31:0] b,
                       logic [15:0] imm, logic [31:0] sd);
    logic [31:0] ea;
    int ofs;
    nMemValid = v && opc[5:4] == 2'b11 && opc[1:0] != 2'b11;
    nMemWrite = nMemValid && opc[2];
    nSize = opc[1:0];
    ea = a + (opc[3] ? {{16{imm[15]}}, imm} : b);
    if (nSize == 1) ea[0] = 1'b0;
    if (nSize == 2) ea[1:0] = 2'b00;
    ofs = int'(ea[1:0]);
    nAddr = nMemValid ? ea : 32'h0;
    nEn = 4'h0;
    nWdata = 32'h0;
    if (nMemWrite) begin
      case (nSize)
        0: begin nEn = 4'b1000 >> ofs; nWdata = {4{sd[7:0]}}; end
        1: begin nEn = (ofs == 0) ? 4'b1100 : 4'b0011; nWdata = {2{sd[15:0]}}; end
        default: begin nEn = 4'b1111; nWdata = sd; end
      endcase
    end
  endtask

  // one clock: drive at negedge, compare at the next negedge
  task automatic step(bit v, logic [5:0] opc, logic [31:0] a, logic [31:0] b,
                      logic [15:0] imm, logic [31:0] sd);
    logic [31:0] w;
    reqValid = v; opcode = opc; opA = a; opB = b; immVal = imm; storeData = sd;
    model(v, opc, a, b, imm, sd);
    @(posedge clk);
    @(negedge clk);
    eMemValid = nMemValid; eMemWrite = nMemWrite; eAddr = nAddr;
    eEn = nEn; eWdata = nWdata; eSize = nSize;
    // R8 and R7: access presence one cycle after request
    check(memValid == eMemValid, "R8 memValid", 32'(memValid), 32'(eMemValid));
    check(memWrite == eMemWrite, "R9 memWrite", 32'(memWrite), 32'(eMemWrite));
    check(byteEn == eEn, "R4 byteEn", 32'(byteEn), 32'(eEn));
    if (eMemValid)
      check(memAddr == eAddr, (eSize == 0) ? "R2 memAddr" : "R3 memAddr",
            memAddr, eAddr);
    if (eMemWrite)
      check(writeData == eWdata, "R5 writeData", writeData, eWdata);
    // load stage result of the previous access
    check(loadValid == eLdValid, "R7 loadValid", 32'(loadValid), 32'(eLdValid));
    check(loadResult == eLoad, "R6 loadResult", loadResult, eLoad);
    // expectation for next cycle's load stage, from memory as it is now
    eLdValid = eMemValid && !eMemWrite;
    eLoad = 32'h0;
    if (eLdValid) begin
      w = mem[eAddr[7:2]];
      case (eSize)
        0: eLoad = (w >> (8 * (3 - int'(eAddr[1:0])))) & 32'hFF;
        1: eLoad = (w >> (8 * (2 - int'(eAddr[1:0])))) & 32'hFFFF;
        default: eLoad = w;
      endcase
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [5:0] opcs [14];
    opcs = '{6'h30, 6'h31, 6'h32, 6'h34, 6'h35, 6'h36, 6'h38,
             6'h39, 6'h3A, 6'h3C, 6'h3D, 6'h3E, 6'h33, 6'h27};
    repeat (3) @(negedge clk);
    // R1: reset state
    check(memValid == 0 && memWrite == 0 && loadValid == 0 && byteEn == 0,
          "R1 reset outputs", {memValid, memWrite, loadValid, byteEn}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(memValid == 0 && byteEn == 0, "R1 after release",
          {memValid, byteEn}, 32'h0);

    // R2: register and immediate address forms, negative immediate
    step(1, 6'h30, 32'h100, 32'h7, 16'h0, 0);
    step(1, 6'h38, 32'h100, 32'hFFFF, 16'hFFFD, 0);
    // R4/R5: byte stores at each offset
    for (int k = 0; k < 4; k++)
      step(1, 6'h3C, 32'h40, 0, 16'(k), 32'hDEADBE00 | 32'(k + 1));
    // R6: byte loads back from the same word, each offset
    for (int k = 0; k < 4; k++)
      step(1, 6'h38, 32'h40, 0, 16'(k), 0);
    // R3/R4/R5: halfword stores, misaligned offsets masked
    step(1, 6'h35, 32'h80, 32'h1, 0, 32'h1234ABCD);
    step(1, 6'h3D, 32'h80, 0, 16'h3, 32'h55667788);
    // R6: halfword loads both halves, misaligned
    step(1, 6'h31, 32'h81, 32'h0, 0, 0);
    step(1, 6'h39, 32'h80, 0, 16'h2, 0);
    // R3: word store and load with misaligned sum
    step(1, 6'h36, 32'hC3, 32'h0, 0, 32'hCAFEF00D);
    step(1, 6'h3A, 32'hC0, 0, 16'h2, 0);
    step(1, 6'h32, 32'hC1, 32'h2, 0, 0);
    // R8: idle, invalid size, outside group
    step(0, 6'h32, 32'h10, 0, 0, 0);
    step(1, 6'h33, 32'h10, 0, 0, 0);
    step(1, 6'h3F, 32'h10, 0, 0, 32'hFFFFFFFF);
    step(1, 6'h26, 32'h10, 0, 0, 32'hFFFFFFFF);
    // R9: store then load of same word back to back
    step(1, 6'h34, 32'h20, 32'h2, 0, 32'h000000A7);
    step(1, 6'h30, 32'h20, 32'h2, 0, 0);
    // random mix covering every requirement
    for (int n = 0; n < 400; n++)
      step(($urandom % 8) != 0, opcs[$urandom % 14], $urandom, $urandom % 256,
           16'($urandom), $urandom);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    finish_run();
  end

endmodule